// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Bank

A bank of eight input-only interrupt channels. Each pin is brought into the bus clock domain through a chain of synchronizer flops. The synchronized level is then compared with its value from one cycle earlier. Three configuration bits per channel choose among five trigger types:

- rising edge
- falling edge
- either edge
- high level
- low level

A qualifying event sets the channel's pending bit. Pending bits are gated by the enable bits and then ORed into one interrupt line.

Software reaches the bank through a plain 32-bit register port. Writes take effect on the clock edge on which the write strobe is high. Reads are combinational from the address. Only the low eight bits of each register carry state; the upper bits read as zero.

Top module: `irq_bank`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low. A zero configuration means: edge mode, single edge, falling polarity, all channels disabled.
- R2: Registers at offsets 0x00 (enable), 0x10 (mode: 1 = level, 0 = edge), 0x14 (both-edge) and 0x18 (polarity) are read/write. Bit n belongs to channel n. Only bits 7:0 are stored, and bits 31:8 read as 0.
- R3: Offset 0x1C returns the synchronized pin levels. A pin change applied before clock edge k is visible from edge k+1 onward, because it passes through two synchronizer flops.
- R4: With mode 0, both-edge 0 and polarity 1, a rising pin sets the pending bit (offset 0x04) on the third clock edge after the change. A falling pin does not set it.
- R5: With mode 0, both-edge 0 and polarity 0, a falling pin sets the pending bit. A rising pin does not set it.
- R6: With mode 0 and both-edge 1, both transitions set the pending bit, and polarity has no effect.
- R7: With mode 1, the pending bit is set while the pin equals the polarity bit (1 = high, 0 = low). A clear has no lasting effect while that level persists.
- R8: Writing to offset 0x0C clears each pending bit whose data bit is 1 and leaves bits written 0 unchanged. Offset 0x0C reads as 0.
- R9: A trigger in the same cycle as a clear of that channel wins, so the pending bit stays 1.
- R10: Offset 0x08 reads pending AND enable. `irq_o` is high exactly when that value is nonzero.
- R11: Writes to offsets 0x04, 0x08 and 0x1C change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low reset |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| pins_i | input | 8 | Asynchronous interrupt inputs |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a clear write that lands in the one cycle in which an edge trigger is live. From the ports, that cycle is the third clock edge after the pin moves. The stimulus first sets a channel's pending bit. It then drives a second rising edge on the same pin and issues the clear exactly two falling clock edges later, so that the write and the trigger are sampled on the same rising edge. A second case is level mode: the bench clears a channel while its active level is held, and expects the bit to read back as still set.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
   localparam int unsigned OFF_ENA = 'h00;
   localparam int unsigned OFF_RAW = 'h04;
   localparam int unsigned OFF_MSK = 'h08;
   localparam int unsigned OFF_CLR = 'h0C;
   localparam int unsigned OFF_LVL = 'h10;
   localparam int unsigned OFF_ANY = 'h14;
   localparam int unsigned OFF_POL = 'h18;
   localparam int unsigned OFF_PIN = 'h1C;

   // per-channel trigger selection
   typedef struct packed {
      logic lvl;   // 1: level sensitive, 0: edge sensitive
      logic any;   // edge mode: every transition
      logic pol;   // 1: rising/high, 0: falling/low
   } trig_cfg_t;
endpackage

// File: rtl/irqb_sync.sv
module irqb_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[0] <= '0;
      else         stage_q[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) stage_q[s] <= '0;
         else         stage_q[s] <= stage_q[s-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqb_detect.sv
module irqb_detect
   import irqb_pkg::*;
(
   input  logic      cur_i,
   input  logic      prev_i,
   input  trig_cfg_t cfg_i,
   output logic      trig_o
);
   logic rise, fall;

   assign rise = cur_i & ~prev_i;
   assign fall = ~cur_i & prev_i;

   always_comb begin
      if (cfg_i.lvl)      trig_o = (cur_i == cfg_i.pol);
      else if (cfg_i.any) trig_o = rise | fall;
      else                trig_o = cfg_i.pol ? rise : fall;
   end
endmodule

// File: rtl/irqb_regs.sv
module irqb_regs
   import irqb_pkg::*;
#(
   parameter int unsigned CHANNELS = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic                bus_wr_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   output logic [DATA_W-1:0]   bus_rdata_o,
   input  logic [CHANNELS-1:0] trig_i,
   input  logic [CHANNELS-1:0] level_i,
   output trig_cfg_t           cfg_o [CHANNELS],
   output logic [CHANNELS-1:0] raw_o,
   output logic [CHANNELS-1:0] masked_o
);
   logic [CHANNELS-1:0] ena_q, lvl_q, any_q, pol_q, raw_q, clr_mask;
   logic [CHANNELS-1:0] wbits;

   assign wbits    = bus_wdata_i[CHANNELS-1:0];
   assign clr_mask = (bus_wr_i && bus_addr_i == ADDR_W'(OFF_CLR)) ? wbits : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ena_q <= '0;
         lvl_q <= '0;
         any_q <= '0;
         pol_q <= '0;
         raw_q <= '0;
      end else begin
         if (bus_wr_i && bus_addr_i == ADDR_W'(OFF_ENA)) ena_q <= wbits;
         if (bus_wr_i && bus_addr_i == ADDR_W'(OFF_LVL)) lvl_q <= wbits;
         if (bus_wr_i && bus_addr_i == ADDR_W'(OFF_ANY)) any_q <= wbits;
         if (bus_wr_i && bus_addr_i == ADDR_W'(OFF_POL)) pol_q <= wbits;
         // a live trigger beats a simultaneous clear
         raw_q <= (raw_q & ~clr_mask) | trig_i;
      end
   end

   for (genvar c = 0; c < CHANNELS; c++) begin : g_cfg
      assign cfg_o[c] = '{lvl: lvl_q[c], any: any_q[c], pol: pol_q[c]};
   end

   assign raw_o    = raw_q;
   assign masked_o = raw_q & ena_q;

   always_comb begin
      bus_rdata_o = '0;
      if      (bus_addr_i == ADDR_W'(OFF_ENA)) bus_rdata_o[CHANNELS-1:0] = ena_q;
      else if (bus_addr_i == ADDR_W'(OFF_RAW)) bus_rdata_o[CHANNELS-1:0] = raw_q;
      else if (bus_addr_i == ADDR_W'(OFF_MSK)) bus_rdata_o[CHANNELS-1:0] = raw_q & ena_q;
      else if (bus_addr_i == ADDR_W'(OFF_LVL)) bus_rdata_o[CHANNELS-1:0] = lvl_q;
      else if (bus_addr_i == ADDR_W'(OFF_ANY)) bus_rdata_o[CHANNELS-1:0] = any_q;
      else if (bus_addr_i == ADDR_W'(OFF_POL)) bus_rdata_o[CHANNELS-1:0] = pol_q;
      else if (bus_addr_i == ADDR_W'(OFF_PIN)) bus_rdata_o[CHANNELS-1:0] = level_i;
   end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
   import irqb_pkg::*;
#(
   parameter int unsigned CHANNELS    = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic                bus_wr_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   output logic [DATA_W-1:0]   bus_rdata_o,
   input  logic [CHANNELS-1:0] pins_i,
   output logic                irq_o
);
   localparam int unsigned MIN_ADDR_W = $clog2(OFF_PIN + 1);

   if (CHANNELS < 1 || CHANNELS > DATA_W) begin : g_bad_channels
      $error("irq_bank: CHANNELS must lie in 1..DATA_W");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("irq_bank: ADDR_W too narrow for the register map");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_bank: SYNC_STAGES must be at least 2");
   end

   logic [CHANNELS-1:0] level_w, prev_q, trig_w, raw_q, masked_w;
   trig_cfg_t           cfg_w [CHANNELS];

   irqb_sync #(.WIDTH(CHANNELS), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pins_i),
      .q_o   (level_w)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= level_w;
   end

   for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
      irqb_detect u_det (
         .cur_i (level_w[c]),
         .prev_i(prev_q[c]),
         .cfg_i (cfg_w[c]),
         .trig_o(trig_w[c])
      );
   end

   irqb_regs #(.CHANNELS(CHANNELS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .bus_addr_i (bus_addr_i),
      .bus_wr_i   (bus_wr_i),
      .bus_wdata_i(bus_wdata_i),
      .bus_rdata_o(bus_rdata_o),
      .trig_i     (trig_w),
      .level_i    (level_w),
      .cfg_o      (cfg_w),
      .raw_o      (raw_q),
      .masked_o   (masked_w)
   );

   assign irq_o = |masked_w;
endmodule

// File: rtl/irqb_checker.sv
module irqb_checker
   import irqb_pkg::*;
#(
   parameter int unsigned CHANNELS = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 8
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic [ADDR_W-1:0]   bus_addr_i,
   input logic                bus_wr_i,
   input logic [DATA_W-1:0]   bus_wdata_i,
   input logic [DATA_W-1:0]   bus_rdata_o,
   input logic                irq_o,
   input logic [CHANNELS-1:0] trig_w,
   input logic [CHANNELS-1:0] raw_q
);
   AST_RAW_NEEDS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((raw_q & ~$past(raw_q) & ~$past(trig_w)) == '0)); // R4

   AST_TRIG_SETS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|trig_w) |=> ((raw_q & $past(trig_w)) == $past(trig_w))); // R9

   AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && bus_addr_i == ADDR_W'(OFF_CLR))
      |=> ((raw_q & $past(bus_wdata_i[CHANNELS-1:0]) & ~$past(trig_w)) == '0)); // R8

   AST_RAW_READONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && bus_addr_i == ADDR_W'(OFF_RAW) && trig_w == '0)
      |=> (raw_q == $past(raw_q))); // R11

   AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_addr_i == ADDR_W'(OFF_MSK)) |-> ((bus_rdata_o != '0) == irq_o)); // R10
endmodule

bind irq_bank irqb_checker #(.CHANNELS(CHANNELS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .bus_addr_i (bus_addr_i),
   .bus_wr_i   (bus_wr_i),
   .bus_wdata_i(bus_wdata_i),
   .bus_rdata_o(bus_rdata_o),
   .irq_o      (irq_o),
   .trig_w     (trig_w),
   .raw_q      (raw_q)
);

// File: tb/sim_irq_bank.sv
module sim_irq_bank;
   localparam logic [7:0] A_ENA = 8'h00, A_RAW = 8'h04, A_MSK = 8'h08, A_CLR = 8'h0C,
                          A_LVL = 8'h10, A_ANY = 8'h14, A_POL = 8'h18, A_PIN = 8'h1C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [7:0]  pins = '0;
   logic        irq;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   always #4 clk = ~clk;   // 125 MHz

   irq_bank u0 (
      .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pins_i(pins), .irq_o(irq)
   );

   // monitor: pops expected items and compares them with the design outputs
   initial begin
      forever begin
         item_t it;
         wait (sb.size() != 0);
         it = sb.pop_front();
         checks++;
         if (it.is_irq) begin
            if (irq !== it.exp[0]) begin
               failures++;
               $display("FAIL %s irq actual=%b expected=%b", it.tag, irq, it.exp[0]);
            end
         end else if (rdata !== it.exp) begin
            failures++;
            $display("FAIL %s rdata actual=%h expected=%h", it.tag, rdata, it.exp);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      addr = a;
      #1;
      sb.push_back('{is_irq: 1'b0, exp: e, tag: tag});
   endtask

   task automatic irq_chk(input bit e, input string tag);
      @(negedge clk);
      #1;
      sb.push_back('{is_irq: 1'b1, exp: {31'd0, e}, tag: tag});
   endtask

   task automatic set_pins(input logic [7:0] p);
      @(negedge clk);
      pins = p;
      tick(3);
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      // R1 reset state
      rd_chk(A_ENA, 32'h0, "R1 enable");
      rd_chk(A_RAW, 32'h0, "R1 raw");
      rd_chk(A_LVL, 32'h0, "R1 mode");
      rd_chk(A_POL, 32'h0, "R1 polarity");
      irq_chk(1'b0, "R1 irq");

      // R2 read/write config, upper bits dropped
      wr_reg(A_ENA, 32'hFFFF_FFA5);
      rd_chk(A_ENA, 32'h0000_00A5, "R2 enable");
      wr_reg(A_ANY, 32'h1234_5633);
      rd_chk(A_ANY, 32'h0000_0033, "R2 both-edge");
      wr_reg(A_ENA, 32'h0);
      rd_chk(A_CLR, 32'h0, "R8 clear reads zero");

      // R11 read-only registers
      wr_reg(A_RAW, 32'hFF);
      rd_chk(A_RAW, 32'h0, "R11 raw not writable");
      wr_reg(A_PIN, 32'hFF);
      rd_chk(A_PIN, 32'h0, "R11 pin data not writable");

      // R3 pin readback after two flops
      @(negedge clk);
      pins = 8'h3C;
      tick(1);
      rd_chk(A_PIN, 32'h3C, "R3 pin level");

      // config: ch0 rise, ch1 fall, ch2 both, ch3 high level, ch4 low level
      wr_reg(A_LVL, 32'h18);
      wr_reg(A_ANY, 32'h04);
      wr_reg(A_POL, 32'h09);
      set_pins(8'h10);
      wr_reg(A_CLR, 32'hFF);
      rd_chk(A_RAW, 32'h0, "R8 baseline cleared");

      // R4 rising
      set_pins(8'h11);
      rd_chk(A_RAW, 32'h01, "R4 rise sets");
      wr_reg(A_CLR, 32'h01);
      rd_chk(A_RAW, 32'h00, "R8 clear bit0");
      set_pins(8'h10);
      rd_chk(A_RAW, 32'h00, "R4 fall ignored");

      // R5 falling
      set_pins(8'h12);
      rd_chk(A_RAW, 32'h00, "R5 rise ignored");
      set_pins(8'h10);
      rd_chk(A_RAW, 32'h02, "R5 fall sets");
      wr_reg(A_CLR, 32'h02);

      // R6 both edges
      set_pins(8'h14);
      rd_chk(A_RAW, 32'h04, "R6 rise sets");
      wr_reg(A_CLR, 32'h04);
      set_pins(8'h10);
      rd_chk(A_RAW, 32'h04, "R6 fall sets");
      wr_reg(A_CLR, 32'h04);

      // R7 level high / low
      set_pins(8'h18);
      rd_chk(A_RAW, 32'h08, "R7 high level sets");
      wr_reg(A_CLR, 32'h08);
      rd_chk(A_RAW, 32'h08, "R7 high level persists");
      set_pins(8'h10);
      wr_reg(A_CLR, 32'h08);
      rd_chk(A_RAW, 32'h00, "R7 high gone clears");
      set_pins(8'h00);
      rd_chk(A_RAW, 32'h10, "R7 low level sets");
      wr_reg(A_CLR, 32'h10);
      rd_chk(A_RAW, 32'h10, "R7 low level persists");
      set_pins(8'h10);
      wr_reg(A_CLR, 32'h10);
      rd_chk(A_RAW, 32'h00, "R7 low gone clears");

      // R8 partial clear
      set_pins(8'h15);
      rd_chk(A_RAW, 32'h05, "R8 two pending");
      wr_reg(A_CLR, 32'h04);
      rd_chk(A_RAW, 32'h01, "R8 only written bit cleared");
      wr_reg(A_CLR, 32'h01);
      set_pins(8'h10);
      wr_reg(A_CLR, 32'hFF);

      // R10 masking and irq
      wr_reg(A_ENA, 32'h01);
      set_pins(8'h11);
      rd_chk(A_MSK, 32'h01, "R10 masked bit");
      irq_chk(1'b1, "R10 irq high");
      wr_reg(A_ENA, 32'h02);
      rd_chk(A_MSK, 32'h00, "R10 masked off");
      irq_chk(1'b0, "R10 irq low when disabled");
      rd_chk(A_RAW, 32'h01, "R10 raw unaffected by enable");
      wr_reg(A_ENA, 32'h01);
      irq_chk(1'b1, "R10 irq back");
      wr_reg(A_CLR, 32'h01);
      irq_chk(1'b0, "R10 irq after clear");

      // R9 edge in same cycle as clear
      set_pins(8'h10);
      @(negedge clk);
      pins = 8'h11;                // ch0 pending already 0; set it first
      tick(3);
      rd_chk(A_RAW, 32'h01, "R9 pre-set");
      set_pins(8'h10);
      @(negedge clk);
      pins = 8'h11;
      @(negedge clk);
      @(negedge clk);
      addr = A_CLR; wdata = 32'h01; wr = 1'b1;   // sampled with the live trigger
      @(negedge clk);
      wr = 1'b0;
      rd_chk(A_RAW, 32'h01, "R9 edge beats clear");
      wr_reg(A_CLR, 32'h01);
      rd_chk(A_RAW, 32'h00, "R9 later clear works");

      wait (sb.size() == 0);
      tick(1);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule